// File: doc/BRIEF.md
# Real-Time Clock with Alarms

This block keeps calendar-independent time for a chip that has a slow oscillator domain. A one-cycle enable pulse, `tick_4k`, arrives 4096 times a second. A 4-bit prescaler turns every sixteenth pulse into a sub-second step, so an 8-bit sub-second count advances at 256 Hz. When the sub-second count wraps, it carries into a 32-bit seconds count. Two alarms run from this time base. The time-of-day alarm fires when the low 20 bits of the seconds count reach a programmed value. The periodic alarm counts sub-second steps down from a programmable reload value and starts again each time it expires.

Software reaches the block through a single-cycle word write/read port with a 3-bit word address. The map is: 0 seconds, 1 sub-seconds, 2 time-of-day alarm, 3 periodic reload, 4 control. Words written to the two counters are not applied at once. They are staged and moved into the counting chain over two tick periods, and a busy flag shows this transfer. A ready pulse marks each sub-second step. A square-wave pin can show one of four rates taken from the existing dividers. Three interrupt outputs combine each event flag with its enable.

Top module: `rtc_core`

## Requirements
- R1: After reset, every count, alarm value, reload value and control bit reads as zero, and `irq_tod`, `irq_ssa`, `irq_rdy` and `sqw_out` are low.
- R2: While running, the sub-second count (address 1) advances by one on every sixteenth `tick_4k` pulse. The seconds count (address 0) increments by one exactly on the step where the sub-second count goes from 0xFF to 0x00, and it wraps from 0xFFFFFFFF to 0.
- R3: The time-of-day flag (control bit 6) sets when a seconds increment makes the low 20 bits of the seconds count equal the value at address 2. The upper 12 bits take no part in the match. `irq_tod` is high while both bit 6 and the enable bit 1 are set.
- R4: Writing address 3 stores a reload value and loads the countdown with it. On each sub-second step, a countdown of 0 or 1 sets the periodic flag (control bit 7) and reloads; any other value decrements. A reload of N≥1 therefore fires every N steps. `irq_ssa` is high while both bit 7 and the enable bit 2 are set.
- R5: Both alarm flags stay set until a control write puts 0 in their bit. Writing 1 to a flag bit leaves it unchanged.
- R6: A write to address 0 or 1 is ignored when the write-enable control bit 15 is clear. It changes nothing and raises no busy.
- R7: An accepted write to address 0 or 1 sets busy (control bit 3). The new value is applied on the second following `tick_4k` pulse, and busy drops at that same point. Counter writes made while busy is set are ignored.
- R8: The ready bit (control bit 4) is high for exactly the one cycle that follows each sub-second step. `irq_rdy` is high when ready and its enable bit 5 are both set.
- R9: When the read-enable control bit 14 is clear, reads of address 0 and 1 return zero. Other addresses read back normally.
- R10: `sqw_out` is low when control bit 8 is clear. Otherwise the select field in bits 10:9 chooses the source. 0 gives sub-second bit 7 (1 Hz). 1 gives prescaler bit 2 (512 Hz). 2 gives a one-cycle pulse in the cycle after each `tick_4k`. 3 gives the system clock divided by 8 with 50% duty.
- R11: With the run bit (control bit 0) clear, `tick_4k` has no effect. The prescaler, sub-second count, seconds count, countdown and `sqw_out` all hold, although staged counter writes still complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_4k | input | 1 | One-cycle 4096 Hz enable pulse |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 3 | Word address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word |
| irq_tod | output | 1 | Time-of-day alarm interrupt |
| irq_ssa | output | 1 | Periodic sub-second alarm interrupt |
| irq_rdy | output | 1 | Sub-second update interrupt |
| sqw_out | output | 1 | Square-wave output |

## Verification
The bench loads the sub-second count just below 0xFF and the seconds count at 0xFFFFFFFF. A carry taken one step early or late, or a seconds count that does not wrap, shows up in the read-back values. It places time-of-day matches where the upper seconds bits are non-zero, so a design that compares all 32 bits never raises the flag. It walks the staged-write window one tick at a time, so a design that applies the value at once, or accepts a second write while busy, returns the wrong count mid-window. Stopped intervals with ticks still arriving expose a prescaler, countdown or square wave that keeps moving. Random reload values and tick runs catch an off-by-one period in the countdown.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_SEC = 3'd0;
  localparam logic [ADDR_W-1:0] A_SUB = 3'd1;
  localparam logic [ADDR_W-1:0] A_TOD = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTL = 3'd4;

  localparam int B_RUN    = 0;
  localparam int B_TOD_IE = 1;
  localparam int B_SSA_IE = 2;
  localparam int B_BUSY   = 3;
  localparam int B_RDY    = 4;
  localparam int B_RDY_IE = 5;
  localparam int B_TOD_F  = 6;
  localparam int B_SSA_F  = 7;
  localparam int B_SQW_EN = 8;
  localparam int B_SEL_LO = 9;
  localparam int B_RD_OK  = 14;
  localparam int B_WR_OK  = 15;

  typedef enum logic [1:0] {
    SQW_SLOW = 2'd0,
    SQW_MID  = 2'd1,
    SQW_TICK = 2'd2,
    SQW_DIV  = 2'd3
  } sqw_sel_e;

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int PRE_W = 4,
  parameter int DIV_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick_4k,
  output logic mid_bit,
  output logic div_bit,
  output logic t4_q,
  output logic ss_tick
);
  localparam logic [PRE_W-1:0] PRE_LAST = '1;
  localparam int MID_IDX = PRE_W - 2;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             t4_d;

  // next state; all state moves only while running
  always_comb begin
    pre_d = pre_q;
    div_d = div_q + 1'b1;
    t4_d  = tick_4k;
    if (tick_4k) pre_d = pre_q + 1'b1;
  end

  assign ss_tick = run & tick_4k & (pre_q == PRE_LAST);
  assign mid_bit = pre_q[MID_IDX];
  assign div_bit = div_q[DIV_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
      t4_q  <= 1'b0;
    end else if (run) begin
      pre_q <= pre_d;
      div_q <= div_d;
      t4_q  <= t4_d;
    end
  end
endmodule

// File: rtl/rtc_time.sv
module rtc_time #(
  parameter int SUB_W      = 8,
  parameter int SEC_W      = 32,
  parameter int TOD_W      = 20,
  parameter int XFER_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_4k,
  input  logic             ss_tick,
  input  logic             wr_sec,
  input  logic             wr_sub,
  input  logic [SEC_W-1:0] sec_wdata,
  input  logic [SUB_W-1:0] sub_wdata,
  output logic [SEC_W-1:0] sec_q,
  output logic [SUB_W-1:0] sub_q,
  output logic             busy,
  output logic             sec_inc,
  output logic [TOD_W-1:0] sec_nxt_low
);
  localparam int XC_W = $clog2(XFER_TICKS + 1);
  localparam logic [XC_W-1:0] XC_LOAD = XC_W'(XFER_TICKS);
  localparam logic [XC_W-1:0] XC_ONE  = XC_W'(1);
  localparam logic [SUB_W-1:0] SUB_LAST = '1;

  logic [SEC_W-1:0] sec_d, stage_sec_q, stage_sec_d;
  logic [SUB_W-1:0] sub_d, stage_sub_q, stage_sub_d;
  logic             pend_sec_q, pend_sec_d, pend_sub_q, pend_sub_d;
  logic [XC_W-1:0]  xc_q, xc_d;
  logic             accept, xfer_done;

  assign busy      = (xc_q != '0);
  assign accept    = (wr_sec | wr_sub) & ~busy;
  assign xfer_done = busy & tick_4k & (xc_q == XC_ONE);
  assign sec_inc   = ss_tick & (sub_q == SUB_LAST) & ~(xfer_done & pend_sec_q);

  always_comb begin
    xc_d        = xc_q;
    stage_sec_d = stage_sec_q;
    stage_sub_d = stage_sub_q;
    pend_sec_d  = pend_sec_q;
    pend_sub_d  = pend_sub_q;
    if (accept) begin
      xc_d        = XC_LOAD;
      pend_sec_d  = wr_sec;
      pend_sub_d  = wr_sub;
      stage_sec_d = sec_wdata;
      stage_sub_d = sub_wdata;
    end else if (busy && tick_4k) begin
      xc_d = xc_q - 1'b1;
    end
  end

  always_comb begin
    sub_d = sub_q;
    sec_d = sec_q;
    if (ss_tick) sub_d = sub_q + 1'b1;
    if (sec_inc) sec_d = sec_q + 1'b1;
    if (xfer_done && pend_sub_q) sub_d = stage_sub_q;
    if (xfer_done && pend_sec_q) sec_d = stage_sec_q;
  end

  assign sec_nxt_low = sec_d[TOD_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xc_q        <= '0;
      stage_sec_q <= '0;
      stage_sub_q <= '0;
      pend_sec_q  <= 1'b0;
      pend_sub_q  <= 1'b0;
      sec_q       <= '0;
      sub_q       <= '0;
    end else begin
      xc_q        <= xc_d;
      stage_sec_q <= stage_sec_d;
      stage_sub_q <= stage_sub_d;
      pend_sec_q  <= pend_sec_d;
      pend_sub_q  <= pend_sub_d;
      sec_q       <= sec_d;
      sub_q       <= sub_d;
    end
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int TOD_W = 20,
  parameter int RLD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_inc,
  input  logic [TOD_W-1:0] sec_low,
  input  logic             ss_tick,
  input  logic             wr_tod,
  input  logic             wr_rld,
  input  logic [TOD_W-1:0] tod_wdata,
  input  logic [RLD_W-1:0] rld_wdata,
  input  logic             clr_tod,
  input  logic             clr_ssa,
  output logic [TOD_W-1:0] tod_q,
  output logic [RLD_W-1:0] rld_q,
  output logic [RLD_W-1:0] cnt_q,
  output logic             tod_flag,
  output logic             ssa_flag
);
  localparam logic [RLD_W-1:0] CNT_ONE = RLD_W'(1);

  logic [TOD_W-1:0] tod_d;
  logic [RLD_W-1:0] rld_d, cnt_d;
  logic             tod_flag_d, ssa_flag_d;
  logic             tod_hit, ssa_hit;

  assign tod_hit = sec_inc & (sec_low == tod_q);
  assign ssa_hit = ss_tick & (cnt_q <= CNT_ONE);

  always_comb begin
    tod_d = wr_tod ? tod_wdata : tod_q;
    rld_d = wr_rld ? rld_wdata : rld_q;
    cnt_d = cnt_q;
    if (wr_rld)       cnt_d = rld_wdata;
    else if (ssa_hit) cnt_d = rld_q;
    else if (ss_tick) cnt_d = cnt_q - 1'b1;
    // a new event wins over a clear in the same cycle
    tod_flag_d = tod_hit | (tod_flag & ~clr_tod);
    ssa_flag_d = ssa_hit | (ssa_flag & ~clr_ssa);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tod_q    <= '0;
      rld_q    <= '0;
      cnt_q    <= '0;
      tod_flag <= 1'b0;
      ssa_flag <= 1'b0;
    end else begin
      tod_q    <= tod_d;
      rld_q    <= rld_d;
      cnt_q    <= cnt_d;
      tod_flag <= tod_flag_d;
      ssa_flag <= ssa_flag_d;
    end
  end
endmodule

// File: rtl/rtc_sqw.sv
module rtc_sqw
  import rtc_pkg::*;
(
  input  logic     en,
  input  sqw_sel_e sel,
  input  logic     slow_bit,
  input  logic     mid_bit,
  input  logic     tick_bit,
  input  logic     div_bit,
  output logic     sqw
);
  logic src;

  always_comb begin
    unique case (sel)
      SQW_SLOW: src = slow_bit;
      SQW_MID:  src = mid_bit;
      SQW_TICK: src = tick_bit;
      default:  src = div_bit;
    endcase
  end

  assign sqw = en & src;
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SUB_W      = 8,
  parameter int SEC_W      = 32,
  parameter int TOD_W      = 20,
  parameter int RLD_W      = 32,
  parameter int PRE_W      = 4,
  parameter int DIV_W      = 3,
  parameter int XFER_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_4k,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_tod,
  output logic              irq_ssa,
  output logic              irq_rdy,
  output logic              sqw_out
);
  // reset: asserted at once, released through two flops
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // control fields
  logic     ctl_run, ctl_tod_ie, ctl_ssa_ie, ctl_rdy_ie, ctl_sqw_en, ctl_rd_ok, ctl_wr_ok;
  sqw_sel_e ctl_sel;
  logic     ctl_run_d, ctl_tod_ie_d, ctl_ssa_ie_d, ctl_rdy_ie_d, ctl_sqw_en_d, ctl_rd_ok_d, ctl_wr_ok_d;
  sqw_sel_e ctl_sel_d;
  logic     rdy_q;

  logic wr_ctl, wr_sec, wr_sub, wr_tod, wr_rld, clr_tod, clr_ssa;

  assign wr_ctl  = wr_en & (addr == A_CTL);
  assign wr_sec  = wr_en & (addr == A_SEC) & ctl_wr_ok;
  assign wr_sub  = wr_en & (addr == A_SUB) & ctl_wr_ok;
  assign wr_tod  = wr_en & (addr == A_TOD);
  assign wr_rld  = wr_en & (addr == A_RLD);
  assign clr_tod = wr_ctl & ~wdata[B_TOD_F];
  assign clr_ssa = wr_ctl & ~wdata[B_SSA_F];

  always_comb begin
    ctl_run_d    = ctl_run;
    ctl_tod_ie_d = ctl_tod_ie;
    ctl_ssa_ie_d = ctl_ssa_ie;
    ctl_rdy_ie_d = ctl_rdy_ie;
    ctl_sqw_en_d = ctl_sqw_en;
    ctl_sel_d    = ctl_sel;
    ctl_rd_ok_d  = ctl_rd_ok;
    ctl_wr_ok_d  = ctl_wr_ok;
    if (wr_ctl) begin
      ctl_run_d    = wdata[B_RUN];
      ctl_tod_ie_d = wdata[B_TOD_IE];
      ctl_ssa_ie_d = wdata[B_SSA_IE];
      ctl_rdy_ie_d = wdata[B_RDY_IE];
      ctl_sqw_en_d = wdata[B_SQW_EN];
      ctl_sel_d    = sqw_sel_e'(wdata[B_SEL_LO +: 2]);
      ctl_rd_ok_d  = wdata[B_RD_OK];
      ctl_wr_ok_d  = wdata[B_WR_OK];
    end
  end

  // datapath
  logic             ss_tick, mid_bit, div_bit, t4_q;
  logic [SEC_W-1:0] sec_q;
  logic [SUB_W-1:0] sub_q;
  logic             busy, sec_inc;
  logic [TOD_W-1:0] sec_nxt_low, tod_q;
  logic [RLD_W-1:0] rld_q, ssa_cnt;
  logic             tod_flag, ssa_flag;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_run    <= 1'b0;
      ctl_tod_ie <= 1'b0;
      ctl_ssa_ie <= 1'b0;
      ctl_rdy_ie <= 1'b0;
      ctl_sqw_en <= 1'b0;
      ctl_sel    <= SQW_SLOW;
      ctl_rd_ok  <= 1'b0;
      ctl_wr_ok  <= 1'b0;
      rdy_q      <= 1'b0;
    end else begin
      ctl_run    <= ctl_run_d;
      ctl_tod_ie <= ctl_tod_ie_d;
      ctl_ssa_ie <= ctl_ssa_ie_d;
      ctl_rdy_ie <= ctl_rdy_ie_d;
      ctl_sqw_en <= ctl_sqw_en_d;
      ctl_sel    <= ctl_sel_d;
      ctl_rd_ok  <= ctl_rd_ok_d;
      ctl_wr_ok  <= ctl_wr_ok_d;
      rdy_q      <= ss_tick;
    end
  end

  rtc_prescale #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (ctl_run),
    .tick_4k (tick_4k),
    .mid_bit (mid_bit),
    .div_bit (div_bit),
    .t4_q    (t4_q),
    .ss_tick (ss_tick)
  );

  rtc_time #(.SUB_W(SUB_W), .SEC_W(SEC_W), .TOD_W(TOD_W), .XFER_TICKS(XFER_TICKS)) u_time (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tick_4k     (tick_4k),
    .ss_tick     (ss_tick),
    .wr_sec      (wr_sec),
    .wr_sub      (wr_sub),
    .sec_wdata   (wdata[SEC_W-1:0]),
    .sub_wdata   (wdata[SUB_W-1:0]),
    .sec_q       (sec_q),
    .sub_q       (sub_q),
    .busy        (busy),
    .sec_inc     (sec_inc),
    .sec_nxt_low (sec_nxt_low)
  );

  rtc_alarm #(.TOD_W(TOD_W), .RLD_W(RLD_W)) u_alarm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sec_inc   (sec_inc),
    .sec_low   (sec_nxt_low),
    .ss_tick   (ss_tick),
    .wr_tod    (wr_tod),
    .wr_rld    (wr_rld),
    .tod_wdata (wdata[TOD_W-1:0]),
    .rld_wdata (wdata[RLD_W-1:0]),
    .clr_tod   (clr_tod),
    .clr_ssa   (clr_ssa),
    .tod_q     (tod_q),
    .rld_q     (rld_q),
    .cnt_q     (ssa_cnt),
    .tod_flag  (tod_flag),
    .ssa_flag  (ssa_flag)
  );

  rtc_sqw u_sqw (
    .en       (ctl_sqw_en),
    .sel      (ctl_sel),
    .slow_bit (sub_q[SUB_W-1]),
    .mid_bit  (mid_bit),
    .tick_bit (t4_q),
    .div_bit  (div_bit),
    .sqw      (sqw_out)
  );

  assign irq_tod = tod_flag & ctl_tod_ie;
  assign irq_ssa = ssa_flag & ctl_ssa_ie;
  assign irq_rdy = rdy_q & ctl_rdy_ie;

  // read mux
  always_comb begin
    rdata = '0;
    unique case (addr)
      A_SEC: if (ctl_rd_ok) rdata[SEC_W-1:0] = sec_q;
      A_SUB: if (ctl_rd_ok) rdata[SUB_W-1:0] = sub_q;
      A_TOD: rdata[TOD_W-1:0] = tod_q;
      A_RLD: rdata[RLD_W-1:0] = rld_q;
      A_CTL: begin
        rdata[B_RUN]         = ctl_run;
        rdata[B_TOD_IE]      = ctl_tod_ie;
        rdata[B_SSA_IE]      = ctl_ssa_ie;
        rdata[B_BUSY]        = busy;
        rdata[B_RDY]         = rdy_q;
        rdata[B_RDY_IE]      = ctl_rdy_ie;
        rdata[B_TOD_F]       = tod_flag;
        rdata[B_SSA_F]       = ssa_flag;
        rdata[B_SQW_EN]      = ctl_sqw_en;
        rdata[B_SEL_LO +: 2] = ctl_sel;
        rdata[B_RD_OK]       = ctl_rd_ok;
        rdata[B_WR_OK]       = ctl_wr_ok;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
  parameter int SUB_W = 8,
  parameter int SEC_W = 32,
  parameter int RLD_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             ss_tick,
  input logic [SUB_W-1:0] sub_q,
  input logic [SEC_W-1:0] sec_q,
  input logic             busy,
  input logic             rdy_q,
  input logic             acc_wr,
  input logic [RLD_W-1:0] ssa_cnt,
  input logic [RLD_W-1:0] rld_q,
  input logic             tod_flag,
  input logic             clr_tod
);
  localparam logic [SUB_W-1:0] SUB_LAST = '1;

  AST_SEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_tick && sub_q == SUB_LAST && !busy) |=> (sec_q == $past(sec_q) + 1'b1)); // R2

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !busy) |=> ($stable(sub_q) && $stable(sec_q))); // R11

  AST_RDY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |=> !rdy_q); // R8

  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(acc_wr)); // R7

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ssa_cnt <= rld_q); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_flag && !clr_tod) |=> tod_flag); // R5
endmodule

bind rtc_core rtc_core_chk #(.SUB_W(SUB_W), .SEC_W(SEC_W), .RLD_W(RLD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .run      (ctl_run),
  .ss_tick  (ss_tick),
  .sub_q    (sub_q),
  .sec_q    (sec_q),
  .busy     (busy),
  .rdy_q    (rdy_q),
  .acc_wr   (wr_sec | wr_sub),
  .ssa_cnt  (ssa_cnt),
  .rld_q    (rld_q),
  .tod_flag (tod_flag),
  .clr_tod  (clr_tod)
);

// File: tb/tb_rtc_core.sv
module tb_rtc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_4k = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_tod, irq_ssa, irq_rdy, sqw_out;

  rtc_core dut (
    .clk(clk), .rst_n(rst_n), .tick_4k(tick_4k), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_tod(irq_tod), .irq_ssa(irq_ssa),
    .irq_rdy(irq_rdy), .sqw_out(sqw_out)
  );

  always #10 clk = ~clk;

  localparam logic [31:0] C_RUN = 32'h1, C_TODIE = 32'h2, C_SSAIE = 32'h4;
  localparam logic [31:0] C_RDYIE = 32'h20, C_KEEP = 32'hC0, C_SQWEN = 32'h100;
  localparam logic [31:0] C_RD = 32'h4000, C_WR = 32'h8000;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  // reference model
  int unsigned m_pre = 0;
  logic [7:0]  m_sub = '0;
  logic [31:0] m_sec = '0, m_rld = '0, m_cnt = '0, m_ctl = '0;
  logic [19:0] m_tod = '0;
  bit          m_todf = 0, m_ssaf = 0, m_ss_last = 0;

  task automatic finish_tb();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  function automatic void adv_sub();
    if (m_sub == 8'hFF) begin
      m_sec = m_sec + 1;
      if (m_sec[19:0] == m_tod) m_todf = 1;
    end
    m_sub = m_sub + 1;
    if (m_cnt <= 1) begin m_ssaf = 1; m_cnt = m_rld; end
    else m_cnt = m_cnt - 1;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 3'd4) begin
      m_ctl = d;
      if (!d[6]) m_todf = 0;
      if (!d[7]) m_ssaf = 0;
    end else if (a == 3'd2) m_tod = d[19:0];
    else if (a == 3'd3) begin m_rld = d; m_cnt = d; end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic tk();
    tick_4k = 1'b1;
    @(negedge clk);
    tick_4k = 1'b0;
    m_ss_last = 0;
    if (m_ctl[0]) begin
      if (m_pre == 15) begin adv_sub(); m_ss_last = 1; end
      m_pre = (m_pre + 1) % 16;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tk();
  endtask

  // counter write with counting stopped; lands after two ticks
  task automatic load(input logic [2:0] a, input logic [31:0] v);
    wr(a, v);
    tk();
    tk();
    if (a == 3'd0) m_sec = v; else m_sub = v[7:0];
  endtask

  task automatic check_time(input string req);
    logic [31:0] v;
    rd(3'd0, v); chk(req, "seconds", v, m_sec);
    rd(3'd1, v); chk(req, "subsec", v, {24'd0, m_sub});
  endtask

  task automatic check_flags(input string req);
    logic [31:0] v;
    rd(3'd4, v);
    chk(req, "tod flag", {31'd0, v[6]}, {31'd0, m_todf});
    chk(req, "ssa flag", {31'd0, v[7]}, {31'd0, m_ssaf});
    chk(req, "irq_tod", {31'd0, irq_tod}, {31'd0, m_todf & m_ctl[1]});
    chk(req, "irq_ssa", {31'd0, irq_ssa}, {31'd0, m_ssaf & m_ctl[2]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_tb();
  end

  initial begin
    logic [31:0] v, s0, s1;
    int ones;
    logic [7:0] smp;
    int unsigned seed;
    seed = 32'd914;
    v = $urandom(seed);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    rd(3'd4, v); chk("R1", "control", v, 32'd0);
    rd(3'd2, v); chk("R1", "tod alarm", v, 32'd0);
    rd(3'd3, v); chk("R1", "reload", v, 32'd0);
    chk("R1", "outputs", {28'd0, irq_tod, irq_ssa, irq_rdy, sqw_out}, 32'd0);
    wr(3'd4, C_RD);
    check_time("R1");

    // R9: read-enable gates counter reads
    wr(3'd4, C_RD | C_WR);
    load(3'd0, 32'h1234_5678);
    check_time("R9");
    wr(3'd4, C_WR);
    rd(3'd0, v); chk("R9", "seconds hidden", v, 32'd0);
    rd(3'd3, v); chk("R9", "reload visible", v, 32'd0);

    // R6: write-enable clear ignores counter writes
    wr(3'd4, C_RD);
    wr(3'd0, 32'hDEAD_BEEF);
    rd(3'd4, v); chk("R6", "no busy", {31'd0, v[3]}, 32'd0);
    tk(); tk();
    check_time("R6");

    // R7: staged transfer with busy
    wr(3'd4, C_RD | C_WR);
    wr(3'd0, 32'hCAFE_0001);
    rd(3'd4, v); chk("R7", "busy set", {31'd0, v[3]}, 32'd1);
    wr(3'd1, 32'h55);
    rd(3'd0, v); chk("R7", "old seconds", v, m_sec);
    tk();
    rd(3'd4, v); chk("R7", "busy after 1 tick", {31'd0, v[3]}, 32'd1);
    rd(3'd0, v); chk("R7", "seconds pending", v, m_sec);
    tk();
    m_sec = 32'hCAFE_0001;
    rd(3'd4, v); chk("R7", "busy cleared", {31'd0, v[3]}, 32'd0);
    check_time("R7");

    // R2 + R8: carry, wrap and ready pulse
    load(3'd1, 32'hFD);
    load(3'd0, 32'hFFFF_FFFF);
    wr(3'd4, C_RD | C_WR | C_RUN);
    for (int i = 0; i < 48; i++) begin
      tk();
      if (m_ss_last || i % 7 == 0) begin
        rd(3'd4, v); chk("R8", "ready bit", {31'd0, v[4]}, {31'd0, m_ss_last});
      end
    end
    check_time("R2");
    wr(3'd4, C_RD | C_WR | C_RUN | C_RDYIE);
    do tk(); while (!m_ss_last);
    chk("R8", "irq_rdy high", {31'd0, irq_rdy}, 32'd1);
    @(negedge clk);
    chk("R8", "irq_rdy one cycle", {31'd0, irq_rdy}, 32'd0);

    // R3: time-of-day match on low 20 bits only
    wr(3'd4, C_RD | C_WR);
    wr(3'd2, 32'h0000_0005);
    load(3'd0, 32'hABC0_0004);
    load(3'd1, 32'hFF);
    wr(3'd4, C_RD | C_WR | C_RUN | C_TODIE);
    do tk(); while (!m_ss_last);
    rd(3'd4, v); chk("R3", "tod flag set", {31'd0, v[6]}, 32'd1);
    chk("R3", "irq_tod", {31'd0, irq_tod}, 32'd1);
    check_time("R3");

    // R5: sticky flags, write 1 keeps, write 0 clears
    wr(3'd4, C_RD | C_WR | C_RUN | C_TODIE | C_KEEP);
    ticks(3);
    rd(3'd4, v); chk("R5", "flag kept", {31'd0, v[6]}, 32'd1);
    wr(3'd4, C_RD | C_WR | C_RUN | C_TODIE);
    rd(3'd4, v); chk("R5", "flag cleared", {31'd0, v[6]}, 32'd0);
    chk("R5", "irq_tod low", {31'd0, irq_tod}, 32'd0);

    // R4: periodic alarm with reload 3
    wr(3'd3, 32'd3);
    wr(3'd4, C_RD | C_WR | C_RUN | C_SSAIE);
    for (int k = 0; k < 10; k++) begin
      do tk(); while (!m_ss_last);
      check_flags("R4");
      if (m_ssaf) wr(3'd4, C_RD | C_WR | C_RUN | C_SSAIE | 32'h40);
    end

    // R11: stopped block ignores ticks
    wr(3'd4, C_RD | C_WR | C_SQWEN | 32'h600 | C_KEEP);
    rd(3'd0, s0); rd(3'd1, s1);
    v = {31'd0, sqw_out};
    for (int i = 0; i < 40; i++) begin
      tk();
      chk("R11", "sqw held", {31'd0, sqw_out}, v);
    end
    rd(3'd0, v); chk("R11", "seconds held", v, s0);
    rd(3'd1, v); chk("R11", "subsec held", v, s1);
    check_flags("R11");

    // R10: clock divided by 8
    wr(3'd4, C_RD | C_WR | C_RUN | C_SQWEN | 32'h600 | C_KEEP);
    ones = 0;
    for (int i = 0; i < 8; i++) begin smp[i] = sqw_out; ones += sqw_out; @(negedge clk); end
    chk("R10", "div8 duty", ones, 4);
    chk("R10", "div8 period", {31'd0, smp[0] ^ smp[4]}, 32'd1);
    // R10: tick pulse mode
    wr(3'd4, C_RD | C_WR | C_RUN | C_SQWEN | 32'h400 | C_KEEP);
    tk();
    chk("R10", "tick pulse high", {31'd0, sqw_out}, 32'd1);
    @(negedge clk);
    chk("R10", "tick pulse low", {31'd0, sqw_out}, 32'd0);
    // R10: prescaler bit 2
    wr(3'd4, C_RD | C_WR | C_RUN | C_SQWEN | 32'h200 | C_KEEP);
    for (int i = 0; i < 20; i++) begin
      tk();
      chk("R10", "512 Hz source", {31'd0, sqw_out}, {31'd0, m_pre[2]});
    end
    // R10: 1 Hz source is subsecond bit 7
    wr(3'd4, C_RD | C_WR | C_SQWEN | C_KEEP);
    load(3'd1, 32'h80);
    chk("R10", "1 Hz high", {31'd0, sqw_out}, 32'd1);
    load(3'd1, 32'h7F);
    chk("R10", "1 Hz low", {31'd0, sqw_out}, 32'd0);
    // R10: gate off
    wr(3'd4, C_RD | C_WR | C_RUN | 32'h600 | C_KEEP);
    ones = 0;
    for (int i = 0; i < 8; i++) begin ones += sqw_out; @(negedge clk); end
    chk("R10", "gated off", ones, 0);

    // random rounds: R2 R3 R4
    for (int r = 0; r < 20; r++) begin
      logic [31:0] rs;
      wr(3'd4, C_RD | C_WR);
      load(3'd1, 32'hE0 + ($urandom % 32));
      rs = $urandom;
      load(3'd0, rs);
      wr(3'd2, {12'd0, 20'(rs + ($urandom % 3))});
      wr(3'd3, 1 + ($urandom % 20));
      wr(3'd4, C_RD | C_WR | C_RUN | C_TODIE | C_SSAIE);
      ticks(1 + ($urandom % 600));
      check_time("R2");
      check_flags("R3");
    end

    finish_tb();
  end
endmodule